// File: doc/BRIEF.md
# DMA Channel Address and Count Register File

This block keeps the programmed start address and the programmed transfer count for each of four DMA channels. It also keeps the live copies that a transfer works from. Software reaches the registers through an 8-bit register port. Every register is 16 bits wide, so each one is moved as two bytes. A single byte-pointer bit, shared by all channels, decides which byte an access touches. The pointer flips on every channel-register access.

A write to the upper byte completes the register. It restarts the channel: the live address is loaded from the programmed address, and the progress counter is cleared. Reads are computed from live state. An address read returns the live address moved forward or backward by the progress made so far. A count read returns the part of the programmed count that is still outstanding.

The parameter `SHIFT` selects the controller width. With 0 it is a byte controller. With 1 it is a word controller: port addresses are spread out by one bit, and address and count values are held in word-shifted form. The control block outside clears the byte pointer and supplies each channel's direction bit. The transfer datapath outside reports progress.

Top module: `dmac_chan_regs`

## Requirements
- R1: After reset the byte pointer is 0, and every programmed base, live address and progress counter is 0. Every register read then returns 0x00.
- R2: The register index is bits 3:0 of (`reg_addr` >> `SHIFT`). Indices 0 to 7 are channel registers: index bits 2:1 give the channel, and index bit 0 selects address (0) or count (1). Address bits above the index have no effect.
- R3: Every channel-register access, read or write, inverts the byte pointer. The access uses the pointer's value from before the inversion: 0 means low byte, 1 means high byte. `ptr_clr` forces the pointer to 0 on the next edge. This takes precedence over an inversion in the same cycle, and the access in that cycle still uses the old value.
- R4: A low-byte write replaces bits 7:0 of the selected base register. It does not change the live address or the progress counter.
- R5: A high-byte write replaces bits 15:8 of the selected base register. It then sets the channel's live address to (base address after this write) << `SHIFT` and its progress counter to 0.
- R6: A count read uses the value ((base count << `SHIFT`) − progress), taken modulo 2^(16+`SHIFT`).
- R7: An address read uses the value (live address + progress) when the channel's `dir_down` bit is 0, and (live address − progress) when it is 1, taken modulo 2^(16+`SHIFT`).
- R8: The byte returned on `rd_data` is bits [`SHIFT`+8·p+7 : `SHIFT`+8·p] of the read value, where p is the pointer before the access. When the cycle is not a channel-register read, `rd_data` is 0x00.
- R9: When `prog_we` is high, `prog_val` is loaded into the progress counter of channel `prog_chan`. If a high-byte write reloads the same channel in the same cycle, the reload wins and the progress counter becomes 0. If the two target different channels, both take effect.
- R10: An access at index 8 to 15 changes no register and does not move the byte pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_en | input | 1 | Register port access strobe, one access per cycle |
| reg_wr | input | 1 | 1 for a write access, 0 for a read access |
| reg_addr | input | 8 | Register port address |
| reg_wdata | input | 8 | Write byte |
| rd_data | output | 8 | Read byte, valid in the cycle of a read access |
| ptr_clr | input | 1 | Synchronous clear of the shared byte pointer |
| dir_down | input | 4 | Per-channel address direction, 1 for decrement |
| prog_we | input | 1 | Progress update strobe from the datapath |
| prog_chan | input | 2 | Channel whose progress is updated |
| prog_val | input | 16+SHIFT | New progress value |

## Verification
Two functions can fall in the same cycle. The first is a restart from a high-byte write. The second is a progress update from the datapath. The bench drives both strobes on the same clock, once for the same channel and once for different channels. It then reads the count back through the port. A same-channel collision must show the full programmed count outstanding. A different-channel collision must show the reported progress on the other channel. The bench also sets `ptr_clr` together with an access, to check that clearing the pointer takes precedence.

// File: rtl/dmac_chan_regs.sv
module dmac_chan_regs #(
  parameter int SHIFT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_wr,
  input  logic [7:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        rd_data,
  input  logic              ptr_clr,
  input  logic [3:0]        dir_down,
  input  logic              prog_we,
  input  logic [1:0]        prog_chan,
  input  logic [16+SHIFT-1:0] prog_val
);
  localparam int CW = 16 + SHIFT;
  localparam int NCH = 4;

  logic [15:0]   base_a [NCH];
  logic [15:0]   base_c [NCH];
  logic [CW-1:0] cur_a  [NCH];
  logic [CW-1:0] prog   [NCH];
  logic          ptr;

  logic [7:0] sh_addr;
  logic [3:0] idx;
  logic [1:0] ch;
  logic       hit, is_cnt, wr_lo, wr_hi;

  assign sh_addr = reg_addr >> SHIFT;
  assign idx     = sh_addr[3:0];
  assign ch      = idx[2:1];
  assign is_cnt  = idx[0];
  assign hit     = reg_en & ~idx[3];
  assign wr_lo   = hit & reg_wr & ~ptr;
  assign wr_hi   = hit & reg_wr & ptr;

  logic [CW-1:0] rval, rsh;
  always_comb begin
    if (is_cnt)
      rval = (CW'(base_c[ch]) << SHIFT) - prog[ch];
    else if (dir_down[ch])
      rval = cur_a[ch] - prog[ch];
    else
      rval = cur_a[ch] + prog[ch];
    rsh = rval >> (SHIFT + (ptr ? 8 : 0));
  end
  assign rd_data = (hit & ~reg_wr) ? rsh[7:0] : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= 1'b0;
    else if (ptr_clr) ptr <= 1'b0;
    else if (hit) ptr <= ~ptr;
  end

  logic [15:0] new_base_a;
  assign new_base_a = is_cnt ? base_a[ch] : {reg_wdata, base_a[ch][7:0]};

  always_ff @(posedge clk) begin
    for (int i = 0; i < NCH; i++) begin
      if (!rst_n) begin
        base_a[i] <= '0;
        base_c[i] <= '0;
        cur_a[i]  <= '0;
        prog[i]   <= '0;
      end else begin
        if (wr_lo && ch == i[1:0]) begin
          if (is_cnt) base_c[i][7:0] <= reg_wdata;
          else        base_a[i][7:0] <= reg_wdata;
        end
        if (prog_we && prog_chan == i[1:0])
          prog[i] <= prog_val;
        if (wr_hi && ch == i[1:0]) begin
          if (is_cnt) base_c[i][15:8] <= reg_wdata;
          else        base_a[i][15:8] <= reg_wdata;
          cur_a[i] <= CW'(new_base_a) << SHIFT;
          prog[i]  <= '0;
        end
      end
    end
  end

  // R3
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !ptr_clr) |=> (ptr != $past(ptr)));
  // R3
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clr |=> !ptr);
  // R10
  idle_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && idx[3] && !ptr_clr) |=> $stable(ptr));
  // R5
  reload_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> (prog[$past(ch)] == '0));
  // R5
  reload_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> (cur_a[$past(ch)] == (CW'(base_a[$past(ch)]) << SHIFT)));
  // R4
  low_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !(prog_we && prog_chan == ch)) |=>
      (cur_a[$past(ch)] == $past(cur_a[ch])) && (prog[$past(ch)] == $past(prog[ch])));
  // R8
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && !reg_wr) |-> (rd_data == 8'h00));
endmodule

// File: tb/sim_dmac_chan_regs.sv
module sim_dmac_chan_regs;
  localparam int S  = 1;
  localparam int CW = 16 + S;
  localparam int M  = (1 << CW) - 1;

  logic clk = 0, rst_n = 0;
  logic reg_en = 0, reg_wr = 0, ptr_clr = 0, prog_we = 0;
  logic [7:0] reg_addr = 0, reg_wdata = 0, rd_data;
  logic [3:0] dir_down = 0;
  logic [1:0] prog_chan = 0;
  logic [CW-1:0] prog_val = 0;

  always #4 clk = ~clk;

  dmac_chan_regs #(.SHIFT(S)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rd_data(rd_data),
    .ptr_clr(ptr_clr), .dir_down(dir_down), .prog_we(prog_we),
    .prog_chan(prog_chan), .prog_val(prog_val));

  int checks = 0, fails = 0;
  int ba[4], bc[4], ca[4], pg[4];
  int tog;
  bit done = 0;

  task automatic step(input bit en, input bit wr, input int port, input int data,
                      input bit clr, input bit pwe, input int pch, input int pval,
                      input string tag);
    int idx, ch, exp, val;
    bit hit;
    @(negedge clk);
    reg_en = en; reg_wr = wr; reg_addr = 8'(port); reg_wdata = 8'(data);
    ptr_clr = clr; prog_we = pwe; prog_chan = 2'(pch); prog_val = CW'(pval);
    idx = (port >> S) & 15;
    ch  = (idx >> 1) & 3;
    hit = en && idx < 8;
    exp = 0;
    if (hit && !wr) begin
      if (idx & 1) val = ((bc[ch] << S) - pg[ch]) & M;
      else if (dir_down[ch]) val = (ca[ch] - pg[ch]) & M;
      else val = (ca[ch] + pg[ch]) & M;
      exp = (val >> (S + 8 * tog)) & 255;
    end
    #2;
    checks++;
    if (rd_data !== 8'(exp)) begin
      fails++;
      $display("FAIL %s: rd_data=%02h expected=%02h", tag, rd_data, exp);
    end
    @(posedge clk);
    if (pwe) pg[pch] = pval & M;
    if (hit && wr) begin
      if (tog == 0) begin
        if (idx & 1) bc[ch] = (bc[ch] & 16'hFF00) | (data & 255);
        else         ba[ch] = (ba[ch] & 16'hFF00) | (data & 255);
      end else begin
        if (idx & 1) bc[ch] = (bc[ch] & 255) | ((data & 255) << 8);
        else         ba[ch] = (ba[ch] & 255) | ((data & 255) << 8);
        ca[ch] = (ba[ch] << S) & M;
        pg[ch] = 0;
      end
    end
    if (clr) tog = 0;
    else if (hit) tog = 1 - tog;
  endtask

  task automatic rd(input int port, input string tag);
    step(1, 0, port, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic wr(input int port, input int data, input string tag);
    step(1, 1, port, data, 0, 0, 0, 0, tag);
  endtask
  function automatic int pa(input int idx);
    return idx << S;
  endfunction

  initial begin
    for (int i = 0; i < 4; i++) begin ba[i] = 0; bc[i] = 0; ca[i] = 0; pg[i] = 0; end
    tog = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    rd(pa(0), "R1"); rd(pa(0), "R1"); rd(pa(7), "R1"); rd(pa(7), "R1");
    // R5 R8 program channel 1 address and read back
    wr(pa(2), 8'h34, "R4"); wr(pa(2), 8'h12, "R5");
    rd(pa(2), "R8"); rd(pa(2), "R8");
    // R6 R9 count with progress
    wr(pa(3), 8'h00, "R4"); wr(pa(3), 8'h01, "R5");
    step(0, 0, 0, 0, 0, 1, 1, 'h10, "R9");
    rd(pa(3), "R6"); rd(pa(3), "R6");
    // R7 address both directions
    rd(pa(2), "R7"); rd(pa(2), "R7");
    dir_down = 4'b0010;
    rd(pa(2), "R7"); rd(pa(2), "R7");
    // R4 low write keeps live state
    wr(pa(2), 8'hAA, "R4");
    step(0, 0, 0, 0, 1, 0, 0, 0, "R3");
    rd(pa(2), "R4"); rd(pa(2), "R4");
    // R3 clear in same cycle as access
    rd(pa(3), "R3");
    step(1, 0, pa(3), 0, 1, 0, 0, 0, "R3");
    rd(pa(3), "R3"); rd(pa(3), "R3");
    // R10 control indices ignored
    wr(pa(8), 8'h55, "R10"); wr(pa(13), 8'h77, "R10");
    rd(pa(15), "R10");
    rd(pa(2), "R10"); rd(pa(2), "R10");
    // R2 upper address bits ignored
    wr(32'h20 | pa(4), 8'hCD, "R2"); wr(32'h40 | pa(4), 8'hAB, "R2");
    rd(32'h80 | pa(4), "R2"); rd(pa(4), "R2");
    // R9 collision, same channel: reload wins
    wr(pa(5), 8'h20, "R9");
    step(1, 1, pa(5), 8'h00, 0, 1, 2, 'h33, "R9");
    rd(pa(5), "R9"); rd(pa(5), "R9");
    // R9 collision, different channels: both apply
    wr(pa(7), 8'h40, "R9");
    step(1, 1, pa(7), 8'h00, 0, 1, 2, 'h21, "R9");
    rd(pa(5), "R9"); rd(pa(5), "R9");
    rd(pa(7), "R9"); rd(pa(7), "R9");
    // R6 count going below zero wraps
    step(0, 0, 0, 0, 0, 1, 3, 'h90, "R6");
    rd(pa(7), "R6"); rd(pa(7), "R6");
    // R7 decrement on channel 3 address
    wr(pa(6), 8'h00, "R5"); wr(pa(6), 8'h00, "R5");
    step(0, 0, 0, 0, 0, 1, 3, 'h8, "R7");
    dir_down = 4'b1000;
    rd(pa(6), "R7"); rd(pa(6), "R7");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule